// File: doc/BRIEF.md
# Free-Running Timer Counter with Coherent Byte Reads

This block is a free-running up-counter, 16 bits wide by default, behind a fixed divide-by-four prescaler. Software reads it one byte at a time over an 8-bit read port. The count appears at two register pairs, a primary pair and an alternate pair. Each pair has a high byte and a low byte.

Reading a high byte freezes the low byte in a shared buffer. A later low-byte read returns that frozen value, so two byte accesses always give one consistent 16-bit sample.

When the count wraps to zero, an overflow flag is set. When the flag is set and the interrupt enable input is high, an interrupt request is raised. Software clears the flag by reading the status location and then reading the primary high byte. The alternate pair lets software sample the time without any risk of clearing the flag.

Counting waits for a run-enable input. This input stands in for the oscillator start-up delay. The bus cannot write the counter.

Top module: `tmr_coherent16`

## Requirements
- R1: While reset is held and after it is released, the count is 0xFFFC (all ones minus three for other widths), the overflow flag is 0 and no low-byte capture is pending.
- R2: With run_en high, the count advances by one every fourth clock. With run_en low, neither the count nor the prescaler phase moves.
- R3: A read with rd_sel = 1 (primary high) or rd_sel = 3 (alternate high) returns count bits [15:8] of the current count. No read changes the count.
- R4: A high read with no capture pending copies the current low byte into the buffer and marks a capture pending. A later read with rd_sel = 2 or rd_sel = 4 (low byte of either pair) returns the buffered byte and ends the pending state.
- R5: While a capture is pending, further high reads of either pair leave the buffer unchanged.
- R6: A low read with no capture pending returns the live count bits [7:0].
- R7: A wrap from all ones to zero sets ovf_flag on the following clock. ovf_irq is high exactly when ovf_flag and ovf_ie are both high.
- R8: A read with rd_sel = 0 returns ovf_flag in bit 7 and zeros in bits 6:0. If such a read sees the flag set, it arms a clear. The next primary high read then clears the flag.
- R9: Reads of the alternate pair, of the status location or of the primary low byte never clear ovf_flag.
- R10: A wrap disarms a pending clear and sets the flag. This holds even when the wrap falls between the two steps of the clear or in the same clock as the primary high read. The flag then stays set until a new status read and primary high read follow.
- R11: rd_data is 0 when rd_en is low, and also when rd_sel is 5, 6 or 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Allows prescaler and counter to run |
| ovf_ie | input | 1 | Overflow interrupt enable |
| rd_en | input | 1 | Read strobe, one access per clock |
| rd_sel | input | 3 | Register select: 0 status, 1 primary high, 2 primary low, 3 alternate high, 4 alternate low |
| rd_data | output | 8 | Read data, valid in the clock of the strobe |
| ovf_flag | output | 1 | Timer overflow flag |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
The assertions check these rules on every clock:
- the count is frozen while run_en is low;
- the flag rises only after the count sat at all ones;
- the flag falls only on an armed primary high read;
- the buffer is held while a capture is pending;
- a read of anything other than the primary high byte never clears a set flag.

Some behaviour only the bench scenarios can show. These are the exact byte values returned for each interleaving of high and low reads, the divide-by-four timing of the count, and the two collision orders between a wrap and the clear sequence. The collision cases use a second instance with a 12-bit counter, so that several wraps fit into one run.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W = 8;
  localparam int SEL_W  = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_STAT = 3'd0,
    SEL_PHI  = 3'd1,
    SEL_PLO  = 3'd2,
    SEL_AHI  = 3'd3,
    SEL_ALO  = 3'd4
  } sel_e;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PRE_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  output logic tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;

  always_comb begin
    pre_d = pre_q;
    if (run_en) pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // terminal phase of the divider gates one count step
  assign tick = run_en & (&pre_q);
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_RST = CNT_MAX - CNT_W'(3);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tick) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_RST;
    else        cnt_q <= cnt_d;
  end

  assign cnt  = cnt_q;
  assign wrap = tick & (cnt_q == CNT_MAX);
endmodule

// File: rtl/tmr_rdlatch.sv
module tmr_rdlatch #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hi_rd,
  input  logic              lo_rd,
  input  logic [BYTE_W-1:0] live_lo,
  output logic              pend,
  output logic [BYTE_W-1:0] lo_buf,
  output logic [BYTE_W-1:0] lo_val
);
  logic              pend_q;
  logic              pend_d;
  logic [BYTE_W-1:0] buf_q;
  logic [BYTE_W-1:0] buf_d;
  logic              capture;

  assign capture = hi_rd & ~pend_q;

  always_comb begin
    buf_d  = buf_q;
    pend_d = pend_q;
    if (capture) begin
      buf_d  = live_lo;
      pend_d = 1'b1;
    end else if (lo_rd) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      buf_q  <= buf_d;
      pend_q <= pend_d;
    end
  end

  assign pend   = pend_q;
  assign lo_buf = buf_q;
  assign lo_val = pend_q ? buf_q : live_lo;
endmodule

// File: rtl/tmr_ovf.sv
module tmr_ovf (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap,
  input  logic stat_rd,
  input  logic phi_rd,
  input  logic ovf_ie,
  output logic flag,
  output logic armed,
  output logic irq
);
  logic flag_q, flag_d;
  logic arm_q, arm_d;

  always_comb begin
    flag_d = flag_q;
    arm_d  = arm_q;
    if (wrap) begin
      flag_d = 1'b1;
      arm_d  = 1'b0;
    end else begin
      if (phi_rd && arm_q) flag_d = 1'b0;
      if (stat_rd && flag_q) arm_d = 1'b1;
      else if (phi_rd)       arm_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flag  = flag_q;
  assign armed = arm_q;
  assign irq   = flag_q & ovf_ie;
endmodule

// File: rtl/tmr_coherent16.sv
module tmr_coherent16 #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run_en,
  input  logic                     ovf_ie,
  input  logic                     rd_en,
  input  logic [tmr_pkg::SEL_W-1:0] rd_sel,
  output logic [tmr_pkg::DATA_W-1:0] rd_data,
  output logic                     ovf_flag,
  output logic                     ovf_irq
);
  import tmr_pkg::*;

  localparam int HI_W = CNT_W - DATA_W;

  generate
    if (HI_W < 1 || HI_W > DATA_W) begin : g_bad_width
      $error("CNT_W must lie between 9 and 16");
    end
  endgenerate

  logic             tick;
  logic             wrap;
  logic [CNT_W-1:0] cnt;
  logic             pend;
  logic             armed;
  logic [DATA_W-1:0] lo_buf;
  logic [DATA_W-1:0] lo_val;
  logic [DATA_W-1:0] hi_val;
  logic             hi_rd, lo_rd, stat_rd, phi_rd;
  sel_e             sel;

  assign sel     = sel_e'(rd_sel);
  assign hi_rd   = rd_en & ((sel == SEL_PHI) | (sel == SEL_AHI));
  assign lo_rd   = rd_en & ((sel == SEL_PLO) | (sel == SEL_ALO));
  assign stat_rd = rd_en & (sel == SEL_STAT);
  assign phi_rd  = rd_en & (sel == SEL_PHI);
  assign hi_val  = DATA_W'(cnt[CNT_W-1:DATA_W]);

  tmr_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick(tick)
  );

  tmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .wrap(wrap)
  );

  tmr_rdlatch #(.BYTE_W(DATA_W)) u_lat (
    .clk(clk), .rst_n(rst_n), .hi_rd(hi_rd), .lo_rd(lo_rd),
    .live_lo(cnt[DATA_W-1:0]), .pend(pend), .lo_buf(lo_buf), .lo_val(lo_val)
  );

  tmr_ovf u_ovf (
    .clk(clk), .rst_n(rst_n), .wrap(wrap), .stat_rd(stat_rd), .phi_rd(phi_rd),
    .ovf_ie(ovf_ie), .flag(ovf_flag), .armed(armed), .irq(ovf_irq)
  );

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      case (sel)
        SEL_STAT:         rd_data = {ovf_flag, {(DATA_W-1){1'b0}}};
        SEL_PHI, SEL_AHI: rd_data = hi_val;
        SEL_PLO, SEL_ALO: rd_data = lo_val;
        default:          rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/tmr_coherent16_chk.sv
module tmr_coherent16_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             ovf_ie,
  input logic             rd_en,
  input logic [2:0]       rd_sel,
  input logic             ovf_flag,
  input logic             ovf_irq,
  input logic [CNT_W-1:0] cnt,
  input logic             pend,
  input logic [7:0]       lo_buf,
  input logic             armed
);
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> $stable(cnt));

  // R7
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> ($past(cnt) == {CNT_W{1'b1}}));

  // R7
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_ie |-> !ovf_irq);

  // R5
  buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !(rd_en && (rd_sel == 3'd2 || rd_sel == 3'd4))) |=> $stable(lo_buf));

  // R9
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !(rd_en && rd_sel == 3'd1)) |=> ovf_flag);

  // R8
  flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf_flag) |-> $past(rd_en && rd_sel == 3'd1 && armed));
endmodule

bind tmr_coherent16 tmr_coherent16_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .ovf_ie(ovf_ie), .rd_en(rd_en),
  .rd_sel(rd_sel), .ovf_flag(ovf_flag), .ovf_irq(ovf_irq), .cnt(cnt),
  .pend(pend), .lo_buf(lo_buf), .armed(armed)
);

// File: tb/sim_tmr_coherent16.sv
module sim_tmr_coherent16;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;
  localparam int N_RAND     = 30000;

  logic       clk;
  logic       rst_n;
  logic       run_en, ovf_ie, rd_en;
  logic [2:0] rd_sel;
  logic [7:0] rd0, rd1;
  logic       fl0, fl1, irq0, irq1;

  int n_chk  = 0;
  int n_fail = 0;

  tmr_coherent16 u0 (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .ovf_ie(ovf_ie), .rd_en(rd_en),
    .rd_sel(rd_sel), .rd_data(rd0), .ovf_flag(fl0), .ovf_irq(irq0)
  );

  tmr_coherent16 #(.CNT_W(12)) u1 (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .ovf_ie(ovf_ie), .rd_en(rd_en),
    .rd_sel(rd_sel), .rd_data(rd1), .ovf_flag(fl1), .ovf_irq(irq1)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // reference state per instance: 0 -> 16-bit, 1 -> 12-bit
  logic [15:0] m_cnt [2];
  logic [15:0] m_max [2];
  logic [1:0]  m_pre [2];
  logic        m_flag[2];
  logic        m_arm [2];
  logic        m_pend[2];
  logic [7:0]  m_buf [2];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_rd(input int i, input bit r, input logic [2:0] s);
    if (!r) return 8'h00;
    case (s)
      3'd0:       return {m_flag[i], 7'b0};
      3'd1, 3'd3: return m_cnt[i][15:8];
      3'd2, 3'd4: return m_pend[i] ? m_buf[i] : m_cnt[i][7:0];
      default:    return 8'h00;
    endcase
  endfunction

  function automatic string rd_tag(input int i, input bit r, input logic [2:0] s);
    if (!r || s > 3'd4) return "R11 rd_data";
    if (s == 3'd0) return "R8 status";
    if (s == 3'd1 || s == 3'd3) return "R3 high";
    if (m_pend[i]) return "R4,R5 buffered low";
    return "R6 live low";
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      m_cnt[i]  = m_max[i] - 16'd3;
      m_pre[i]  = 2'd0;
      m_flag[i] = 1'b0;
      m_arm[i]  = 1'b0;
      m_pend[i] = 1'b0;
      m_buf[i]  = 8'h00;
    end
  endtask

  task automatic model_step(input bit r, input logic [2:0] s, input bit run);
    for (int i = 0; i < 2; i++) begin
      bit tk, wr, hi, lo, st, ph;
      tk = run && (m_pre[i] == 2'd3);
      wr = tk && (m_cnt[i] == m_max[i]);
      hi = r && (s == 3'd1 || s == 3'd3);
      lo = r && (s == 3'd2 || s == 3'd4);
      st = r && (s == 3'd0);
      ph = r && (s == 3'd1);
      if (hi && !m_pend[i]) begin
        m_buf[i]  = m_cnt[i][7:0];
        m_pend[i] = 1'b1;
      end else if (lo) begin
        m_pend[i] = 1'b0;
      end
      if (wr) begin
        m_flag[i] = 1'b1;
        m_arm[i]  = 1'b0;
      end else begin
        if (ph && m_arm[i]) m_flag[i] = 1'b0;
        if (st && m_flag[i]) m_arm[i] = 1'b1;
        else if (ph)         m_arm[i] = 1'b0;
      end
      if (run) m_pre[i] = m_pre[i] + 2'd1;
      if (tk)  m_cnt[i] = (m_cnt[i] + 16'd1) & m_max[i];
    end
  endtask

  // one clock: drive, compare against reference, then advance reference
  task automatic step(input bit r, input logic [2:0] s, input bit run, input bit ie);
    logic [7:0] e0, e1;
    @(negedge clk);
    rd_en = r; rd_sel = s; run_en = run; ovf_ie = ie;
    #1;
    e0 = exp_rd(0, r, s);
    e1 = exp_rd(1, r, s);
    chk(rd0 == e0, {rd_tag(0, r, s), " u0"}, rd0, e0);
    chk(rd1 == e1, {rd_tag(1, r, s), " u1"}, rd1, e1);
    chk(fl0 == m_flag[0], "R7,R9,R10 flag u0", fl0, m_flag[0]);
    chk(fl1 == m_flag[1], "R7,R9,R10 flag u1", fl1, m_flag[1]);
    chk(irq0 == (m_flag[0] & ie), "R7 irq u0", irq0, m_flag[0] & ie);
    chk(irq1 == (m_flag[1] & ie), "R7 irq u1", irq1, m_flag[1] & ie);
    @(posedge clk);
    model_step(r, s, run);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d cycles expected=completion", WD_CYCLES);
    summary();
    $finish;
  end

  initial begin
    int guard;
    void'($urandom(32'd20240611));
    m_max[0] = 16'hFFFF;
    m_max[1] = 16'h0FFF;
    rd_en = 1'b0; rd_sel = 3'd0; run_en = 1'b0; ovf_ie = 1'b0;
    rst_n = 1'b0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset value and flag, read with the counter held
    step(1'b1, 3'd1, 1'b0, 1'b1);
    chk(rd0 == 8'hFF, "R1 reset high", rd0, 8'hFF);
    chk(fl0 == 1'b0,  "R1 reset flag", fl0, 0);
    step(1'b1, 3'd2, 1'b0, 1'b1);
    chk(rd0 == 8'hFC, "R1 reset low", rd0, 8'hFC);

    // R2: held while run_en low, then one step after four running clocks
    repeat (6) step(1'b0, 3'd0, 1'b0, 1'b0);
    step(1'b1, 3'd2, 1'b0, 1'b0);
    chk(rd0 == 8'hFC, "R2 held", rd0, 8'hFC);
    repeat (3) step(1'b0, 3'd0, 1'b1, 1'b0);
    step(1'b1, 3'd2, 1'b0, 1'b0);
    chk(rd0 == 8'hFC, "R2 three clocks", rd0, 8'hFC);
    step(1'b0, 3'd0, 1'b1, 1'b0);
    step(1'b1, 3'd2, 1'b0, 1'b0);
    chk(rd0 == 8'hFD, "R2 four clocks", rd0, 8'hFD);

    // R5: alternate high captures, repeated high reads keep buffer, low returns it
    step(1'b1, 3'd3, 1'b1, 1'b0);
    repeat (9) step(1'b1, 3'd1, 1'b1, 1'b0);
    step(1'b1, 3'd4, 1'b1, 1'b0);
    chk(rd0 == 8'hFD, "R5 buffer held", rd0, 8'hFD);

    // mixed random traffic, checked every clock against the reference
    for (int k = 0; k < N_RAND; k++) begin
      bit r, run, ie;
      logic [2:0] s;
      r   = ($urandom % 10) < 6;
      s   = 3'($urandom % 8);
      run = ($urandom % 8) != 0;
      ie  = ($urandom % 4) != 0;
      step(r, s, run, ie);
    end

    // R10: wrap between status read and primary high read (u1)
    guard = 0;
    while (!(m_flag[1] && m_cnt[1] == 16'h0FFF && m_pre[1] == 2'd2) && guard < 40000) begin
      step(1'b0, 3'd0, 1'b1, 1'b1);
      guard++;
    end
    step(1'b1, 3'd0, 1'b1, 1'b1);
    step(1'b0, 3'd0, 1'b1, 1'b1);
    step(1'b1, 3'd1, 1'b1, 1'b1);
    step(1'b0, 3'd0, 1'b1, 1'b1);
    chk(fl1 == 1'b1, "R10 wrap between steps", fl1, 1);

    // R10: wrap in the same clock as the primary high read (u1)
    guard = 0;
    while (!(m_cnt[1] == 16'h0FFF && m_pre[1] == 2'd1) && guard < 40000) begin
      step(1'b0, 3'd0, 1'b1, 1'b1);
      guard++;
    end
    step(1'b1, 3'd0, 1'b1, 1'b1);
    step(1'b0, 3'd0, 1'b1, 1'b1);
    step(1'b1, 3'd1, 1'b1, 1'b1);
    step(1'b0, 3'd0, 1'b0, 1'b1);
    chk(fl1 == 1'b1, "R10 wrap same clock", fl1, 1);

    // R8: undisturbed clear sequence, alternate read in between (R9)
    step(1'b1, 3'd0, 1'b0, 1'b1);
    step(1'b1, 3'd3, 1'b0, 1'b1);
    step(1'b1, 3'd4, 1'b0, 1'b1);
    chk(fl1 == 1'b1, "R9 alternate keeps flag", fl1, 1);
    step(1'b1, 3'd1, 1'b0, 1'b1);
    step(1'b0, 3'd0, 1'b0, 1'b1);
    chk(fl1 == 1'b0, "R8 flag cleared", fl1, 0);
    chk(irq1 == 1'b0, "R7 irq after clear", irq1, 0);
    step(1'b1, 3'd2, 1'b0, 1'b1);

    summary();
    $finish;
  end
endmodule